// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out where a single-register load or store goes in memory and what the base register should hold afterwards. Each request carries a base register value, the program counter, a 12-bit immediate magnitude with an add/subtract bit, an addressing-mode code, a byte/word size flag, a load/store flag and the store data. One cycle later the block presents the effective address, the base writeback enable and value, the byte lane enables, the lane-placed store data and a write strobe. It also returns the load result, taken from the word the memory returns for that address.

Five addressing forms are supported. Plain indirect uses the base as the address. Pre-indexed adds the offset for the access only. Pre-indexed with writeback adds the offset and also returns the sum as the new base. Post-indexed uses the old base for the access and returns base plus offset as the new base. PC-relative adds a bias of 8 and the offset to the program counter. Memory is little-endian and word-organised, so byte accesses pick a lane from the two low address bits.

Top module: `lsagu_top`

## Requirements
- R1: Mode code 0 (and the unused codes 5, 6, 7) gives an address equal to the base, with writeback enable low.
- R2: Mode code 1 gives an address of base plus offset, with writeback enable low.
- R3: Mode code 2 gives an address of base plus offset, with writeback enable high and a writeback value equal to that address.
- R4: Mode code 3 gives an address equal to the unmodified base, with writeback enable high and a writeback value of base plus offset.
- R5: Mode code 4 gives an address of PC plus 8 plus offset, with writeback enable low.
- R6: The offset is the 12-bit magnitude, added when the add/subtract bit is 1 and subtracted when it is 0. All address sums wrap modulo 2^32.
- R7: An aligned word store raises the write strobe with all four lane enables set and the store data passed through unchanged.
- R8: A byte access sets exactly one lane enable, bit k for address bits 1:0 equal to k. A byte store places store data bits 7:0 in every lane of the write data.
- R9: A byte load returns the byte in lane k (bits 8k+7..8k of the memory word) in result bits 7:0, with bits 31:8 zero.
- R10: An aligned word load returns the memory word unchanged.
- R11: A word access whose address bits 1:0 are not zero raises the misalign flag, clears all lane enables and does not raise the write strobe, so memory is left unchanged.
- R12: Every result appears in the cycle after the request is sampled. Without a request in the previous cycle, the response valid, writeback enable, write strobe and misalign flag are all low, and all of them are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing-mode code (0 indirect, 1 pre, 2 pre+writeback, 3 post, 4 PC-relative) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Program counter value |
| off_mag | input | 12 | Immediate offset magnitude |
| off_up | input | 1 | 1 = add offset, 0 = subtract |
| st_data | input | 32 | Store source register value |
| rd_word | input | 32 | Memory word read at mem_addr |
| rsp_valid | output | 1 | Response present this cycle |
| mem_addr | output | 32 | Effective address |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | 32 | New base register value |
| mem_we | output | 1 | Memory write strobe |
| byte_en | output | 4 | Byte lane enables |
| wr_data | output | 32 | Lane-placed store data |
| misalign | output | 1 | Misaligned word access |
| ld_data | output | 32 | Aligned load result |

## Verification
Address, writeback, lane enable, write strobe and misalign results all come from one register stage, so they are due one cycle after the request. The bench records that cycle number with each expected item and compares at the falling edge after that cycle's rising edge. Any other cycle must show no response. The load result follows combinationally from the memory word read at the registered address, so it is checked in the same sample. Stores land in the bench memory at the rising edge after their response. The bench's own reference model applies them in request order, so a load issued right behind a store sees the new data.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  parameter int DW      = 32;
  parameter int OFF_W   = 12;
  parameter int PC_BIAS = 8;
  localparam int LANES  = DW / 8;
  localparam int LN_W   = $clog2(LANES);

  typedef enum logic [2:0] {
    AM_INDIRECT = 3'd0,
    AM_PRE      = 3'd1,
    AM_PRE_WB   = 3'd2,
    AM_POST     = 3'd3,
    AM_PC_REL   = 3'd4
  } am_e;

  // base +/- zero-extended magnitude, wrapping modulo 2^DW
  function automatic logic [DW-1:0] offset_apply(input logic [DW-1:0] base,
                                                 input logic [OFF_W-1:0] mag,
                                                 input logic up);
    logic [DW-1:0] ext;
    ext = {{(DW-OFF_W){1'b0}}, mag};
    return up ? (base + ext) : (base - ext);
  endfunction

  function automatic logic [LANES-1:0] lane_onehot(input logic [LN_W-1:0] lane);
    logic [LANES-1:0] m;
    m = '0;
    m[lane] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lsagu_addr_calc.sv
module lsagu_addr_calc
  import lsagu_pkg::*;
(
  input  logic [2:0]       mode,
  input  logic [DW-1:0]    base,
  input  logic [DW-1:0]    pc,
  input  logic [OFF_W-1:0] mag,
  input  logic             up,
  output logic [DW-1:0]    ea,
  output logic             wb_en,
  output logic [DW-1:0]    wb_val
);
  logic [DW-1:0] base_off;   // base with offset applied
  logic [DW-1:0] pc_anchor;  // pc plus pipeline bias
  logic [DW-1:0] pc_target;

  assign base_off  = offset_apply(base, mag, up);
  assign pc_anchor = pc + DW'(PC_BIAS);
  assign pc_target = offset_apply(pc_anchor, mag, up);

  always_comb begin
    ea     = base;
    wb_en  = 1'b0;
    wb_val = base;
    case (mode)
      AM_PRE: begin
        ea = base_off;
      end
      AM_PRE_WB: begin
        ea     = base_off;
        wb_en  = 1'b1;
        wb_val = base_off;
      end
      AM_POST: begin
        ea     = base;
        wb_en  = 1'b1;
        wb_val = base_off;
      end
      AM_PC_REL: begin
        ea = pc_target;
      end
      default: begin
        ea = base;
      end
    endcase
  end
endmodule

// File: rtl/lsagu_lane_ctl.sv
module lsagu_lane_ctl
  import lsagu_pkg::*;
(
  input  logic [LN_W-1:0]  lane,
  input  logic             is_byte,
  input  logic [DW-1:0]    st_data,
  output logic [LANES-1:0] be,
  output logic [DW-1:0]    wdata,
  output logic             misalign
);
  logic word_off_grid;

  assign word_off_grid = !is_byte && (lane != '0);
  assign misalign      = word_off_grid;

  always_comb begin
    if (is_byte) be = lane_onehot(lane);
    else if (word_off_grid) be = '0;
    else be = '1;
  end

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign wdata[8*k +: 8] = is_byte ? st_data[7:0] : st_data[8*k +: 8];
    end
  endgenerate
endmodule

// File: rtl/lsagu_load_align.sv
module lsagu_load_align
  import lsagu_pkg::*;
(
  input  logic [DW-1:0]   rd_word,
  input  logic [LN_W-1:0] lane,
  input  logic            is_byte,
  output logic [DW-1:0]   ld_data
);
  logic [7:0] lane_byte [LANES];
  logic [7:0] picked;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_split
      assign lane_byte[k] = rd_word[8*k +: 8];
    end
  endgenerate

  assign picked  = lane_byte[lane];
  assign ld_data = is_byte ? {{(DW-8){1'b0}}, picked} : rd_word;
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic             req_store,
  input  logic             req_byte,
  input  logic [DW-1:0]    base_val,
  input  logic [DW-1:0]    pc_val,
  input  logic [OFF_W-1:0] off_mag,
  input  logic             off_up,
  input  logic [DW-1:0]    st_data,
  input  logic [DW-1:0]    rd_word,
  output logic             rsp_valid,
  output logic [DW-1:0]    mem_addr,
  output logic             wb_en,
  output logic [DW-1:0]    wb_val,
  output logic             mem_we,
  output logic [LANES-1:0] byte_en,
  output logic [DW-1:0]    wr_data,
  output logic             misalign,
  output logic [DW-1:0]    ld_data
);
  logic [DW-1:0]    ea_c;
  logic             wbe_c;
  logic [DW-1:0]    wbv_c;
  logic [LANES-1:0] be_c;
  logic [DW-1:0]    wd_c;
  logic             mis_c;

  lsagu_addr_calc u_calc (
    .mode   (req_mode),
    .base   (base_val),
    .pc     (pc_val),
    .mag    (off_mag),
    .up     (off_up),
    .ea     (ea_c),
    .wb_en  (wbe_c),
    .wb_val (wbv_c)
  );

  lsagu_lane_ctl u_lane (
    .lane     (ea_c[LN_W-1:0]),
    .is_byte  (req_byte),
    .st_data  (st_data),
    .be       (be_c),
    .wdata    (wd_c),
    .misalign (mis_c)
  );

  logic             vld_q, wbe_q, we_q, mis_q, byte_q;
  logic [DW-1:0]    addr_q, wbv_q, wd_q;
  logic [LANES-1:0] be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wbe_q  <= 1'b0;
      we_q   <= 1'b0;
      mis_q  <= 1'b0;
      byte_q <= 1'b0;
      addr_q <= '0;
      wbv_q  <= '0;
      wd_q   <= '0;
      be_q   <= '0;
    end else begin
      vld_q <= req_valid;
      wbe_q <= req_valid & wbe_c;
      we_q  <= req_valid & req_store & ~mis_c;
      mis_q <= req_valid & mis_c;
      if (req_valid) begin
        byte_q <= req_byte;
        addr_q <= ea_c;
        wbv_q  <= wbv_c;
        wd_q   <= wd_c;
        be_q   <= be_c;
      end
    end
  end

  lsagu_load_align u_align (
    .rd_word (rd_word),
    .lane    (addr_q[LN_W-1:0]),
    .is_byte (byte_q),
    .ld_data (ld_data)
  );

  assign rsp_valid = vld_q;
  assign mem_addr  = addr_q;
  assign wb_en     = wbe_q;
  assign wb_val    = wbv_q;
  assign mem_we    = we_q;
  assign byte_en   = be_q;
  assign wr_data   = wd_q;
  assign misalign  = mis_q;
endmodule

// File: rtl/lsagu_checker.sv
module lsagu_checker
  import lsagu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_mode,
  input logic             req_byte,
  input logic [DW-1:0]    base_val,
  input logic             rsp_valid,
  input logic [DW-1:0]    mem_addr,
  input logic             wb_en,
  input logic [DW-1:0]    wb_val,
  input logic             mem_we,
  input logic [LANES-1:0] byte_en,
  input logic             misalign
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12
  AST_RSP_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !wb_en && !mem_we && !misalign)); // R12
  AST_INDIRECT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AM_INDIRECT) |=> (mem_addr == $past(base_val) && !wb_en)); // R1
  AST_PRE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AM_PRE) |=> !wb_en); // R2
  AST_PREWB_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AM_PRE_WB) |=> (wb_en && wb_val == mem_addr)); // R3
  AST_POST_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AM_POST) |=> (mem_addr == $past(base_val) && wb_en)); // R4
  AST_PCREL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AM_PC_REL) |=> !wb_en); // R5
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_byte) |=> ($countones(byte_en) == 1 && !misalign)); // R8
  AST_MIS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_we && byte_en == '0)); // R11
endmodule

bind lsagu_top lsagu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .req_byte  (req_byte),
  .base_val  (base_val),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .wb_en     (wb_en),
  .wb_val    (wb_val),
  .mem_we    (mem_we),
  .byte_en   (byte_en),
  .misalign  (misalign)
);

// File: tb/sim_lsagu_top.sv
`timescale 1ns/1ps
module sim_lsagu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic        req_store = 1'b0;
  logic        req_byte = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] pc_val = '0;
  logic [11:0] off_mag = '0;
  logic        off_up = 1'b1;
  logic [31:0] st_data = '0;
  logic [31:0] rd_word;
  logic        rsp_valid, wb_en, mem_we, misalign;
  logic [31:0] mem_addr, wb_val, wr_data, ld_data;
  logic [3:0]  byte_en;

  always #5 clk = ~clk;

  lsagu_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_store(req_store), .req_byte(req_byte), .base_val(base_val),
    .pc_val(pc_val), .off_mag(off_mag), .off_up(off_up), .st_data(st_data),
    .rd_word(rd_word), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
    .wb_en(wb_en), .wb_val(wb_val), .mem_we(mem_we), .byte_en(byte_en),
    .wr_data(wr_data), .misalign(misalign), .ld_data(ld_data)
  );

  // memory model (64 words, indexed by address bits 7:2) and reference copy
  logic [31:0] mem     [64];
  logic [31:0] ref_mem [64];
  assign rd_word = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (mem_we)
      for (int k = 0; k < 4; k++)
        if (byte_en[k]) mem[mem_addr[7:2]][8*k +: 8] <= wr_data[8*k +: 8];
  end

  typedef struct {
    string       tag;
    int          due;
    logic [31:0] addr, wbv, wd, ld;
    logic        wbe, we, mis, chk_ld;
    logic [3:0]  be;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, expv);
    end
  endtask

  task automatic issue(input string tag, input logic [2:0] md, input bit st, input bit by,
                       input logic [31:0] b, input logic [31:0] pc, input logic [11:0] mg,
                       input bit up, input logic [31:0] sd);
    exp_t e;
    logic [31:0] delta, word;
    @(negedge clk);
    req_valid = 1'b1; req_mode = md; req_store = st; req_byte = by;
    base_val = b; pc_val = pc; off_mag = mg; off_up = up; st_data = sd;
    delta = up ? {20'd0, mg} : (32'd0 - {20'd0, mg});
    e.tag = tag; e.due = cyc + 1; e.wbe = 1'b0; e.wbv = '0;
    case (md)
      3'd1: e.addr = b + delta;
      3'd2: begin e.addr = b + delta; e.wbe = 1'b1; e.wbv = b + delta; end
      3'd3: begin e.addr = b; e.wbe = 1'b1; e.wbv = b + delta; end
      3'd4: e.addr = pc + 32'd8 + delta;
      default: e.addr = b;
    endcase
    e.mis = !by && (e.addr[1:0] != 2'b00);
    e.be  = by ? (4'b0001 << e.addr[1:0]) : (e.mis ? 4'b0000 : 4'b1111);
    e.we  = st && !e.mis;
    e.wd  = by ? {4{sd[7:0]}} : sd;
    e.chk_ld = !st && !e.mis;
    word = ref_mem[e.addr[7:2]];
    e.ld = by ? ((word >> (8 * e.addr[1:0])) & 32'hFF) : word;
    if (e.we)
      for (int k = 0; k < 4; k++)
        if (e.be[k]) ref_mem[e.addr[7:2]][8*k +: 8] = e.wd[8*k +: 8];
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk({"R12 ", e.tag}, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(e.tag, "mem_addr", mem_addr, e.addr);
        chk(e.tag, "wb_en", {31'd0, wb_en}, {31'd0, e.wbe});
        if (e.wbe) chk(e.tag, "wb_val", wb_val, e.wbv);
        chk(e.tag, "byte_en", {28'd0, byte_en}, {28'd0, e.be});
        chk(e.tag, "mem_we", {31'd0, mem_we}, {31'd0, e.we});
        chk(e.tag, "misalign", {31'd0, misalign}, {31'd0, e.mis});
        if (e.we) chk(e.tag, "wr_data", wr_data, e.wd);
        if (e.chk_ld) chk(e.tag, "ld_data", ld_data, e.ld);
      end else begin
        chk("R12 idle", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R12 idle", "mem_we", {31'd0, mem_we}, 32'd0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]     = 32'hA500_0000 ^ (i * 32'h0101_0101);
      ref_mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
    end
    repeat (3) @(negedge clk);
    chk("R12 reset", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12 reset", "wb_en", {31'd0, wb_en}, 32'd0);
    chk("R12 reset", "misalign", {31'd0, misalign}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    // R1 plain indirect word load, and unused mode codes behaving alike
    issue("R1 indirect", 3'd0, 0, 0, 32'h0000_0010, 32'h0, 12'd4, 1, 32'h0);
    issue("R1 code5", 3'd5, 0, 0, 32'h0000_0020, 32'h0, 12'd8, 1, 32'h0);
    issue("R1 code7", 3'd7, 0, 0, 32'h0000_0024, 32'h0, 12'd8, 0, 32'h0);
    // R2 pre-indexed, add and subtract (R6)
    issue("R2 pre add", 3'd1, 0, 0, 32'h0000_0040, 32'h0, 12'd4, 1, 32'h0);
    issue("R2 R6 pre sub", 3'd1, 0, 0, 32'h0000_0040, 32'h0, 12'd12, 0, 32'h0);
    // R3 pre-indexed with writeback
    issue("R3 prewb", 3'd2, 0, 0, 32'h0000_0080, 32'h0, 12'd4, 1, 32'h0);
    issue("R3 R6 prewb sub", 3'd2, 0, 0, 32'h0000_0080, 32'h0, 12'd16, 0, 32'h0);
    // R4 post-indexed word store then read back (R7, R10)
    issue("R4 R7 post store", 3'd3, 1, 0, 32'h0000_0030, 32'h0, 12'd4, 1, 32'hDEAD_BEEF);
    issue("R10 readback", 3'd0, 0, 0, 32'h0000_0030, 32'h0, 12'd0, 1, 32'h0);
    // R5 PC-relative
    issue("R5 pcrel add", 3'd4, 0, 0, 32'h1234_5678, 32'h0000_8FE4, 12'd4, 1, 32'h0);
    issue("R5 pcrel sub", 3'd4, 0, 0, 32'h0, 32'h0000_0100, 12'd8, 0, 32'h0);
    // R6 wrap-around both directions
    issue("R6 wrap up", 3'd2, 0, 0, 32'hFFFF_FFFC, 32'h0, 12'd8, 1, 32'h0);
    issue("R6 wrap down", 3'd3, 0, 0, 32'h0000_0004, 32'h0, 12'hFFF, 0, 32'h0);
    issue("R6 max mag", 3'd1, 0, 0, 32'h0000_1000, 32'h0, 12'hFFF, 1, 32'h0);
    // R9 byte loads from each lane
    for (int k = 0; k < 4; k++)
      issue("R9 byte load", 3'd1, 0, 1, 32'h0000_0050, 32'h0, 12'(k), 1, 32'h0);
    // R8 byte stores into each lane, then a word load sees them (R10)
    for (int k = 0; k < 4; k++)
      issue("R8 byte store", 3'd3, 1, 1, 32'h0000_0060 + 32'(k), 32'h0, 12'd1, 1, 32'h1111_1100 + 32'(k * 17));
    issue("R8 R10 merged", 3'd0, 0, 0, 32'h0000_0060, 32'h0, 12'd0, 1, 32'h0);
    // R11 misaligned word store is blocked, memory unchanged
    issue("R11 mis store", 3'd1, 1, 0, 32'h0000_0070, 32'h0, 12'd2, 1, 32'hCAFE_F00D);
    issue("R11 mis load", 3'd0, 0, 0, 32'h0000_0073, 32'h0, 12'd0, 1, 32'h0);
    issue("R11 unchanged", 3'd0, 0, 0, 32'h0000_0070, 32'h0, 12'd0, 1, 32'h0);
    issue("R11 R9 byte ok", 3'd0, 0, 1, 32'h0000_0073, 32'h0, 12'd0, 1, 32'h0);
    // R12 gaps between requests
    idle(3);
    issue("R12 after gap", 3'd2, 1, 1, 32'h0000_0091, 32'h0, 12'd1, 1, 32'h0000_00A7);
    idle(1);
    issue("R9 R12 gap read", 3'd0, 0, 1, 32'h0000_0092, 32'h0, 12'd0, 1, 32'h0);
    idle(4);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12 pending responses: actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule